// File: doc/BRIEF.md
# Serial-Loaded Banked DAC Code Register File

This block is the digital front end of a 36-channel, 8-bit digital-to-analog converter. A host feeds 16-bit words over a three-wire serial link: a data line, a serial clock and a load strobe. All three are synchronized into the system clock domain. Each word enters a 16-bit shift register least significant bit first. A rising edge on the load strobe decodes the word and writes its 8-bit code into one addressed channel register. The most significant bit of the shift register is driven out on a cascade pin so that several devices can be chained on one data line.

Channels 1 to 30 each hold a single code. Channels 31 to 36 each hold four codes, in banks 0 to 3. A 2-bit bank index input, shared by all six channels, picks which bank each of them presents. This choice is combinational, so changing the index updates those outputs with no serial traffic. All 36 active codes are presented in parallel, channel n on bits [8n-1:8n-8].

Top module: `serdac_regfile`

## Requirements
- R1: A word is 16 bits, shifted in first bit = bit 0 (LSB) through last bit = bit 15 (MSB). One data bit is captured for each rising edge of the synchronized serial clock.
- R2: In the shifted word, bits [15:8] are the 8-bit code and bits [5:0] are the target select value. Bits [7:6] have no effect.
- R3: The cascade output always equals bit 15 of the shift register, so after a full 16-bit word it carries that word's bit 15.
- R4: On a load, a select value of 1 to 30 writes the code into channel 1 to 30 respectively.
- R5: A select value s from 31 to 54 writes bank (s-31)/6 of channel 31+((s-31) mod 6). So 31..36 reach bank 0 of channels 31..36, 37..42 reach bank 1, 43..48 reach bank 2 and 49..54 reach bank 3.
- R6: Channels 31 to 36 all present the bank chosen by the 2-bit bank index input (value 0 to 3). A change of the index shows on the outputs combinationally.
- R7: A load with select value 0 or 55 to 63 leaves every stored code unchanged.
- R8: After reset every channel presents code 0 in every bank and the cascade output is 0.
- R9: If the load strobe is first sampled high at system-clock edge k, the write is visible after edge k+2. Holding the strobe high produces exactly one write.
- R10: Serial shifting with no load rising edge changes no channel output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_dat_i | input | 1 | Serial data in, LSB first |
| ser_ld_i | input | 1 | Load strobe, acts on its rising edge |
| bank_sel_i | input | 2 | Bank index for channels 31 to 36 |
| ser_out_o | output | 1 | Cascade output, shift register bit 15 |
| codes_o | output | 288 | All channel codes, channel n at [8n-1:8n-8] |

## Verification
The bench probes the edges of the select map. Channel 1 and channel 30 bound the single-code range, and select values 31, 36, 37, 43, 49 and 54 bound the banked range. An off-by-one decoder would land a code in a neighbouring channel or bank. Values 0, 55 and 63 carry the code 0xFF, so a decoder that wraps or truncates the select value would overwrite a live register. The bit order of the serial word is tested with words whose reversed reading names a different target. The cycle at which a write appears is checked exactly, and a word is shifted while the strobe stays high, which catches a level-triggered load that writes on every shift.

// File: rtl/serdac_regfile.sv
`timescale 1ns/1ps
module serdac_regfile #(
  parameter int CODE_W      = 8,
  parameter int WORD_W      = 16,
  parameter int SEL_W       = 6,
  parameter int NUM_PLAIN   = 30,
  parameter int NUM_BANKED  = 6,
  parameter int NUM_BANKS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    ser_clk_i,
  input  logic                                    ser_dat_i,
  input  logic                                    ser_ld_i,
  input  logic [$clog2(NUM_BANKS)-1:0]            bank_sel_i,
  output logic                                    ser_out_o,
  output logic [(NUM_PLAIN+NUM_BANKED)*CODE_W-1:0] codes_o
);
  localparam int FIRST_BANKED = NUM_PLAIN + 1;
  localparam int LAST_BANKED  = NUM_PLAIN + NUM_BANKED * NUM_BANKS;

  logic [SYNC_STAGES:0]   sck_q, ld_q;
  logic [SYNC_STAGES-1:0] dat_q;
  logic [WORD_W-1:0]      sr;
  logic [NUM_PLAIN-1:0][CODE_W-1:0]                  plain_q;
  logic [NUM_BANKS-1:0][NUM_BANKED-1:0][CODE_W-1:0]  bank_q;

  wire sck_rise = sck_q[SYNC_STAGES-1] & ~sck_q[SYNC_STAGES];
  wire ld_rise  = ld_q[SYNC_STAGES-1]  & ~ld_q[SYNC_STAGES];
  wire [CODE_W-1:0] wdata = sr[WORD_W-1 -: CODE_W];
  wire [SEL_W-1:0]  sel   = sr[SEL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      ld_q  <= '0;
      dat_q <= '0;
    end else begin
      sck_q <= {sck_q[SYNC_STAGES-1:0], ser_clk_i};
      ld_q  <= {ld_q[SYNC_STAGES-1:0], ser_ld_i};
      dat_q <= {dat_q[SYNC_STAGES-2:0], ser_dat_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr <= '0;
    else if (sck_rise) sr <= {dat_q[SYNC_STAGES-1], sr[WORD_W-1:1]};
  end

  assign ser_out_o = sr[WORD_W-1];

  for (genvar p = 0; p < NUM_PLAIN; p++) begin : g_plain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   plain_q[p] <= '0;
      else if (ld_rise && sel == SEL_W'(p + 1))     plain_q[p] <= wdata;
    end
    assign codes_o[p*CODE_W +: CODE_W] = plain_q[p];
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar c = 0; c < NUM_BANKED; c++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          bank_q[b][c] <= '0;
        else if (ld_rise && sel == SEL_W'(FIRST_BANKED + b*NUM_BANKED + c))
          bank_q[b][c] <= wdata;
      end
    end
  end

  for (genvar c = 0; c < NUM_BANKED; c++) begin : g_out
    assign codes_o[(NUM_PLAIN+c)*CODE_W +: CODE_W] = bank_q[bank_sel_i][c];
  end

  // R3
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_rise |=> $stable(ser_out_o));

  // R10
  no_load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_rise |=> ($stable(plain_q) && $stable(bank_q)));

  // R7
  unused_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rise && (sel == '0 || sel > SEL_W'(LAST_BANKED)))
      |=> ($stable(plain_q) && $stable(bank_q)));

  // R4
  first_chan_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rise && sel == SEL_W'(1))
      |=> codes_o[CODE_W-1:0] == $past(sr[WORD_W-1 -: CODE_W]));
endmodule

// File: tb/serdac_regfile_tb.sv
`timescale 1ns/1ps
module serdac_regfile_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, sdi = 1'b0, sld = 1'b0;
  logic [1:0] bsel = 2'd0;
  logic sout;
  logic [287:0] codes;
  int checks = 0, failures = 0;
  bit done = 0;

  serdac_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sck), .ser_dat_i(sdi),
    .ser_ld_i(sld), .bank_sel_i(bsel), .ser_out_o(sout), .codes_o(codes)
  );

  always #5 clk = ~clk;

  // behavioural reference
  int mplain[30];
  int mbank[4][6];
  logic [15:0] msr;
  logic [3:0] hs, hd, hl;

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mplain[i]) mplain[i] = 0;
      foreach (mbank[i, j]) mbank[i][j] = 0;
      msr = '0; hs = '0; hd = '0; hl = '0;
    end else begin
      hs = {hs[2:0], sck};
      hd = {hd[2:0], sdi};
      hl = {hl[2:0], sld};
      if (hl[2] && !hl[3]) begin
        int s, d;
        s = int'(msr[5:0]);
        d = int'(msr[15:8]);
        if (s >= 1 && s <= 30) mplain[s-1] = d;
        else if (s >= 31 && s <= 54) mbank[(s-31)/6][(s-31)%6] = d;
      end
      if (hs[2] && !hs[3]) msr = {hd[2], msr[15:1]};
    end
  end

  function automatic int exp_ch(int k);
    return (k < 30) ? mplain[k] : mbank[bsel][k-30];
  endfunction

  task automatic chk(string tag, int act, int exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int ch(int n);
    return int'(codes[(n-1)*8 +: 8]);
  endfunction

  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      int bad;
      bad = -1;
      for (int k = 0; k < 36; k++)
        if (bad < 0 && int'(codes[k*8 +: 8]) !== exp_ch(k)) bad = k;
      if (bad < 0) chk(bad < 30 ? "R4" : "R6", 0, 0, "model codes");
      else chk(bad < 30 ? "R4" : "R6", int'(codes[bad*8 +: 8]), exp_ch(bad), "model code");
      chk("R3", int'(sout), int'(msr[15]), "model cascade");
    end
  end

  function automatic logic [15:0] wrd(int d, int s);
    return {d[7:0], 2'b11, s[5:0]};
  endfunction

  task automatic shift_word(logic [15:0] w);
    for (int i = 0; i < 16; i++) begin
      sdi = w[i];
      repeat (3) @(negedge clk);
      sck = 1'b1;
      repeat (3) @(negedge clk);
      sck = 1'b0;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_load();
    sld = 1'b1;
    repeat (4) @(negedge clk);
    sld = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic write(int d, int s);
    shift_word(wrd(d, s));
    pulse_load();
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [287:0] snap;
    int prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", (codes == '0) ? 1 : 0, 1, "all codes zero after reset");
    chk("R8", int'(sout), 0, "cascade zero after reset");

    // R1 R2 R4: bits 7:6 set, LSB first
    write(8'hA5, 1);
    chk("R1", ch(1), 8'hA5, "ch1 LSB-first word");
    chk("R2", ch(2), 0, "ch2 untouched");
    write(8'h3C, 30);
    chk("R4", ch(30), 8'h3C, "ch30");

    // R3 cascade after full word
    shift_word(16'h8002);
    chk("R3", int'(sout), 1, "cascade = bit15");
    chk("R10", ch(2), 0, "ch2 unchanged after shift only");
    shift_word(wrd(8'h77, 2));
    chk("R3", int'(sout), 0, "cascade = bit15 of 0x77 word");

    // R9 latency
    prev = ch(2);
    sld = 1'b1;
    @(negedge clk); chk("R9", ch(2), prev, "before edge k+1");
    @(negedge clk); chk("R9", ch(2), prev, "before edge k+2");
    @(negedge clk); chk("R9", ch(2), 8'h77, "after edge k+2");
    // held high: shifting a new word must not write
    shift_word(wrd(8'h34, 2));
    chk("R9", ch(2), 8'h77, "held strobe writes once");
    sld = 1'b0;
    repeat (4) @(negedge clk);

    // R5 banked map
    write(8'h11, 31);
    write(8'h66, 36);
    write(8'h22, 37);
    write(8'h44, 43);
    write(8'h55, 49);
    write(8'h33, 54);
    bsel = 2'd0; #1;
    chk("R5", ch(31), 8'h11, "ch31 bank0");
    chk("R5", ch(36), 8'h66, "ch36 bank0");
    bsel = 2'd1; #1;
    chk("R6", ch(31), 8'h22, "ch31 bank1 combinational");
    chk("R6", ch(36), 0, "ch36 bank1");
    bsel = 2'd2; #1;
    chk("R5", ch(31), 8'h44, "ch31 bank2");
    bsel = 2'd3; #1;
    chk("R5", ch(31), 8'h55, "ch31 bank3");
    chk("R5", ch(36), 8'h33, "ch36 bank3");
    chk("R4", ch(30), 8'h3C, "ch30 not hit by banked writes");
    @(negedge clk);

    // R7 unused codes
    snap = codes;
    write(8'hFF, 0);
    write(8'hFF, 55);
    write(8'hFF, 63);
    chk("R7", (codes == snap) ? 1 : 0, 1, "unused selects change nothing");
    for (int b = 0; b < 4; b++) begin
      bsel = 2'(b);
      @(negedge clk);
      chk("R7", (codes[239:0] == snap[239:0]) ? 1 : 0, 1, "plain channels unchanged");
    end

    done = 1;
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule